// File: doc/BRIEF.md
# Control-Bit Arithmetic Logic Unit

This is a combinational arithmetic logic unit for 16-bit two's complement operands. It has no opcode decoder. Six independent control bits each apply one fixed transform at a fixed point in a chain of stages. Each operand may first be cleared, and the cleared-or-original value may then be bitwise inverted. The two conditioned operands are then either added or bitwise ANDed. The chosen result may finally be inverted.

Chaining these simple steps gives constants, negation, increment and both directions of subtraction from only an adder and an AND array. The adder is a ripple chain of full-adder cells with carry-in tied to 0. Two flags come with the result: one shows that it is zero, and the other copies its sign bit. The block has no clock and no reset, so a result is valid once the logic has settled after an input change.

Top module: `ctl_alu`

## Requirements
- R1: When `clr_a` is 1, operand A enters the inversion stage as 0, whatever `op_a` holds. `clr_b` does the same for operand B.
- R2: When `inv_a` is 1, the value that leaves the clearing stage for A is bitwise inverted before the function stage. `inv_b` does the same for B.
- R3: When `sel_add` is 1, the function result is the sum of the conditioned operands modulo 2^16. A carry out of bit 15 is dropped, so 0xFFFF + 0x0001 gives 0x0000.
- R4: When `sel_add` is 0, the function result is the bitwise AND of the conditioned operands.
- R5: When `inv_out` is 1, `res` is the bitwise inverse of the function result. Otherwise `res` equals the function result.
- R6: `is_zero` is 1 exactly when all 16 bits of `res` are 0.
- R7: `is_neg` equals bit 15 of `res`.
- R8: Control words are written here with the bits in the order clr_a, inv_a, clr_b, inv_b, sel_add, inv_out. Word 101010 gives 0, word 111111 gives 1 and word 111010 gives -1 (0xFFFF), for any operands.
- R9: With the same bit order, word 010011 gives A−B, word 000111 gives B−A, word 011111 gives A+1 and word 001111 gives −A, all modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| clr_a | input | 1 | Clear operand A |
| inv_a | input | 1 | Invert conditioned operand A |
| clr_b | input | 1 | Clear operand B |
| inv_b | input | 1 | Invert conditioned operand B |
| sel_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Invert the function result |
| res | output | 16 | Result |
| is_zero | output | 1 | Result is zero |
| is_neg | output | 1 | Bit 15 of the result |

## Verification
The dropped carry out of bit 15 and the zero flag can both occur in the same evaluation. In that case a sum that wraps, such as 0xFFFF plus 1 or −A computed from A = 0, must still raise `is_zero`. The sign flag can likewise be raised by a sum that overflowed into bit 15, for example 0x7FFF + 1.

These cases are provoked by boundary operand pairs (0, 1, 0x7FFF, 0x8000, 0xFFFF) swept through all 64 control words. Each of these evaluations is judged against a behavioural integer model of the stage chain.

// File: rtl/ctl_alu.sv
`timescale 1ns/1ps
module ctl_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_add,
  input  logic         inv_out,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  localparam int H = W / 2;

  logic [W-1:0] a_z, b_z, a_c, b_c;
  logic [W-1:0] sum_v, and_v, fn_v;
  logic [W-1:0] cy;
  logic         lo_any, hi_any;

  assign a_z = clr_a ? '0 : op_a;
  assign b_z = clr_b ? '0 : op_b;
  assign a_c = inv_a ? ~a_z : a_z;
  assign b_c = inv_b ? ~b_z : b_z;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_v[i] = a_c[i] ^ b_c[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a_c[i] & b_c[i]) | (cy[i] & (a_c[i] ^ b_c[i]));
    end
  end

  assign and_v = a_c & b_c;
  assign fn_v  = sel_add ? sum_v : and_v;
  assign res   = inv_out ? ~fn_v : fn_v;

  assign lo_any  = |res[H-1:0];
  assign hi_any  = |res[W-1:H];
  assign is_zero = ~(lo_any | hi_any);
  assign is_neg  = res[W-1];

  always_comb begin
    // R1
    if (clr_a) clr_a_chk: assert (a_c == {W{inv_a}});
    // R3
    if (sel_add) ripple_sum_chk: assert (sum_v == W'(a_c + b_c));
    // R6
    zero_flag_chk: assert (is_zero == (res == '0));
    // R7
    if (is_neg) sign_flag_chk: assert ($signed(res) < 0);
  end
endmodule

// File: tb/ctl_alu_bench.sv
`timescale 1ns/1ps
module ctl_alu_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] op_a, op_b, res;
  logic [5:0]  ctl;
  logic        is_zero, is_neg;
  int checks = 0, errors = 0;
  bit done = 0;

  ctl_alu u_ctl_alu (
    .op_a(op_a), .op_b(op_b),
    .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]), .inv_b(ctl[2]),
    .sel_add(ctl[1]), .inv_out(ctl[0]),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  function automatic logic [15:0] model(logic [5:0] c, logic [15:0] a, logic [15:0] b);
    int x, y, r;
    x = c[5] ? 0 : int'(a);
    y = c[3] ? 0 : int'(b);
    if (c[4]) x = 65535 - x;
    if (c[2]) y = 65535 - y;
    r = c[1] ? (x + y) % 65536 : (x & y);
    if (c[0]) r = 65535 - r;
    return 16'(r);
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: ctl=%b a=%h b=%h got=%h exp=%h", tag, ctl, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(logic [5:0] c, logic [15:0] a, logic [15:0] b);
    @(posedge clk);
    ctl = c; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  task automatic full_check(logic [15:0] a, logic [15:0] b);
    logic [15:0] e;
    for (int c = 0; c < 64; c++) begin
      apply(6'(c), a, b);
      e = model(6'(c), a, b);
      chk("R1/R2/R3/R4/R5", res, e);
      chk("R6", {15'd0, is_zero}, {15'd0, e == 16'd0});
      chk("R7", {15'd0, is_neg}, {15'd0, e[15]});
    end
  endtask

  logic [15:0] pa [10];
  logic [15:0] pb [10];

  initial begin
    ctl = '0; op_a = '0; op_b = '0;
    pa = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'h0001, 16'hF0F0, 16'hA5A5, 16'h0000, 16'h7FFF};
    pb = '{16'h0000, 16'h0001, 16'h0001, 16'h8000, 16'h4321, 16'hFFFF, 16'h3C3C, 16'h5A5A, 16'h0001, 16'h7FFF};
    @(negedge clk);
    chk("R4", res, 16'h0000);
    chk("R6", {15'd0, is_zero}, 16'd1);

    apply(6'b100000, 16'h1234, 16'hFFFF); chk("R1", res, 16'h0000);
    apply(6'b001000, 16'hFFFF, 16'hBEEF); chk("R1", res, 16'h0000);
    apply(6'b111100, 16'h1234, 16'h5678); chk("R2", res, 16'hFFFF);
    apply(6'b010000, 16'h00FF, 16'hF0F0); chk("R2", res, 16'hF000);
    apply(6'b000010, 16'hFFFF, 16'h0001); chk("R3", res, 16'h0000);
    chk("R6", {15'd0, is_zero}, 16'd1);
    apply(6'b000010, 16'h7FFF, 16'h0001); chk("R3", res, 16'h8000);
    chk("R7", {15'd0, is_neg}, 16'd1);
    apply(6'b000000, 16'hF0F0, 16'h3C3C); chk("R4", res, 16'h3030);
    apply(6'b000001, 16'hF0F0, 16'h3C3C); chk("R5", res, 16'hCFCF);

    for (int p = 0; p < 10; p++) begin
      apply(6'b101010, pa[p], pb[p]); chk("R8", res, 16'h0000);
      apply(6'b111111, pa[p], pb[p]); chk("R8", res, 16'h0001);
      apply(6'b111010, pa[p], pb[p]); chk("R8", res, 16'hFFFF);
      apply(6'b010011, pa[p], pb[p]); chk("R9", res, 16'(pa[p] - pb[p]));
      apply(6'b000111, pa[p], pb[p]); chk("R9", res, 16'(pb[p] - pa[p]));
      apply(6'b011111, pa[p], pb[p]); chk("R9", res, 16'(pa[p] + 16'd1));
      apply(6'b001111, pa[p], pb[p]); chk("R9", res, 16'(16'd0 - pa[p]));
      full_check(pa[p], pb[p]);
    end
    begin
      logic [15:0] s = 16'hACE1;
      for (int k = 0; k < 12; k++) begin
        logic [15:0] a, b;
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; a = s;
        s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; b = s ^ 16'h3A5C;
        full_check(a, b);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule